// File: doc/BRIEF.md
# Edge-Triggered Capture Timer

This block times an external digital input against a prescaled copy of the local clock. Firmware picks one of eight tick rates, from the clock divided by 256 down to the clock divided by 2. It also picks one of four trigger modes. Two modes measure the full period between like edges. The other two measure how long the input stays high or stays low. The input first passes through a two-flop synchroniser. An 8-bit up-counter then runs between the start edge and the stop edge of the chosen mode.

When a measurement closes, the count is copied into a capture register and a done flag is raised. The flag also drives the `irq` output. The flag and the captured value stay put until firmware clears the flag by writing a one to it. In pulse-width modes the counter then stays frozen and waits for firmware. In period modes the counter restarts from zero at the closing edge, so back-to-back periods are measured without firmware help. A count that would pass 0xFF stays at 0xFF and sets a sticky overflow bit. A small four-word register port gives access to control, capture, status and the live count.

Top module: `cap_timer`

## Requirements
- R1: After a synchronous reset, all four register words read 0 and `irq` is low.
- R2: Control field rate (bits 6:4) sets the count tick to the clock divided by 2^(8-rate): 000 gives /256, 110 gives /4 and 111 gives /2. Two ticks never fall on consecutive cycles, and a pulse of N clocks, with N a multiple of the divider, is counted as N divided by the divider.
- R3: Mode 2'b10 (control bits 1:0) measures high time. A rising edge starts counting and a falling edge stops it. The live count then stays frozen, and no new start edge is taken until the done flag is cleared.
- R4: Mode 2'b11 measures low time. A falling edge starts counting and a rising edge stops it.
- R5: Mode 2'b00 measures falling-to-falling period and mode 2'b01 measures rising-to-rising period. At each closing edge the counter restarts from zero, so the next period is captured without firmware writing the count.
- R6: The done flag (status bit 0) sets when a measurement closes and drives `irq`. Writing 1 to status bit 0 clears it. Otherwise it holds.
- R7: The capture word (read at address 1) loads only at a closing edge while the done flag is clear. It does not change while the flag is set.
- R8: With the enable bit (control bit 7) at 0, the counter does not move, edges on `cap_in` are ignored, and the done flag does not set.
- R9: A count that would pass 0xFF saturates at 0xFF and sets the overflow bit (status bit 1). The overflow bit stays set until 1 is written to status bit 1, and that write leaves bit 0 alone.
- R10: Address 3 reads the live counter. A write to address 1 loads the live counter.
- R11: Address 0 holds control: bit 7 enable, bits 6:4 rate, bits 1:0 mode. Bits 3:2 read as 0. `cap_in` passes two synchroniser flops and an edge detector before it reaches the counter control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the source of the prescaled tick |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register word select: 0 control, 1 capture/count load, 2 status, 3 live count |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed word (combinational) |
| cap_in | input | 1 | Asynchronous signal being measured |
| irq | output | 1 | Request to firmware; equals the done flag |

## Verification
Each mode runs with its own divider, and the captured value is compared with the pulse or period length divided by the tick divisor. An off-by-one at the start or stop edge, or a wrong edge polarity, would show up as a wrong capture value or a missing flag.

One pulse is long enough to saturate the counter. A design that wrapped would return a small count and leave the overflow bit clear.

A second pulse is sent while the flag is still set. A design that overwrote the capture or re-armed early would change the capture word or the live count. A second period follows in period mode. A design that did not restart at the closing edge would return the sum of both periods. A disabled run checks that nothing moves.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 3;
    localparam int TRIG_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CAPT = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] A_LIVE = 2'd3;

    typedef enum logic [TRIG_W-1:0] {
        TRG_FALL_PERIOD = 2'b00,
        TRG_RISE_PERIOD = 2'b01,
        TRG_HIGH_WIDTH  = 2'b10,
        TRG_LOW_WIDTH   = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        PH_ARM  = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
        trig_e             trig;
    } ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic is_period(trig_e t);
        return (t == TRG_FALL_PERIOD) || (t == TRG_RISE_PERIOD);
    endfunction

    function automatic logic start_hit(trig_e t, edge_t e);
        case (t)
            TRG_FALL_PERIOD: return e.fall;
            TRG_RISE_PERIOD: return e.rise;
            TRG_HIGH_WIDTH:  return e.rise;
            default:         return e.fall;
        endcase
    endfunction

    function automatic logic stop_hit(trig_e t, edge_t e);
        case (t)
            TRG_FALL_PERIOD: return e.fall;
            TRG_RISE_PERIOD: return e.rise;
            TRG_HIGH_WIDTH:  return e.fall;
            default:         return e.rise;
        endcase
    endfunction

endpackage

// File: rtl/cap_presc.sv
module cap_presc
    import cap_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    // divider 2^(PRE_W-rate): low (PRE_W-rate) bits all ones
    assign mask = {PRE_W{1'b1}} >> rate;
    assign tick = run && ((div_q & mask) == mask);

    // R2: tick period is at least two clocks
    p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ed
);
    logic [SYNC_N-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
    end

    generate
        for (genvar i = 1; i < SYNC_N; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[SYNC_N-1];
    end

    assign ed.rise = chain[SYNC_N-1] & ~last_q;
    assign ed.fall = ~chain[SYNC_N-1] & last_q;

    // R11: a detected edge never reports both polarities
    p_edge_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(ed.rise && ed.fall));

endmodule

// File: rtl/cap_core.sv
module cap_core
    import cap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  edge_t            ed,
    input  logic             clr_done,
    input  logic             clr_ovf,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] live_cnt,
    output logic [CNT_W-1:0] capt,
    output logic             done,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] capt;
        logic             done;
        logic             ovf;
    } core_t;

    core_t cur, nxt;
    logic [CNT_W-1:0] cnt_step;
    logic             sat_hit, go, halt, set_done;

    assign sat_hit  = tick && (cur.cnt == CNT_MAX);
    assign cnt_step = !tick ? cur.cnt : (sat_hit ? CNT_MAX : cur.cnt + 1'b1);
    assign go       = start_hit(ctrl.trig, ed);
    assign halt     = stop_hit(ctrl.trig, ed);

    always_comb begin
        nxt      = cur;
        set_done = 1'b0;
        if (!ctrl.en) begin
            nxt.phase = PH_ARM;
        end else begin
            case (cur.phase)
                PH_ARM: begin
                    if (go) nxt.phase = PH_RUN;
                end
                PH_RUN: begin
                    nxt.cnt = cnt_step;
                    if (sat_hit) nxt.ovf = 1'b1;
                    if (halt) begin
                        if (!cur.done) begin
                            nxt.capt = cnt_step;
                            set_done = 1'b1;
                        end
                        if (is_period(ctrl.trig)) nxt.cnt = '0;
                        else                      nxt.phase = PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (!cur.done) nxt.phase = PH_ARM;
                end
                default: nxt.phase = PH_ARM;
            endcase
        end
        if (cnt_wr)   nxt.cnt  = cnt_wdata;
        if (clr_ovf)  nxt.ovf  = 1'b0;
        if (clr_done) nxt.done = 1'b0;
        if (set_done) nxt.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign live_cnt = cur.cnt;
    assign capt     = cur.capt;
    assign done     = cur.done;
    assign ovf      = cur.ovf;

    // R6: done flag holds until firmware clears it
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cur.done && !clr_done |=> cur.done);

    // R7: capture word frozen while the flag is set
    p_capt_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        cur.done |=> $stable(cur.capt));

    // R8: disabled timer neither counts nor arms
    p_idle_off_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en && !cnt_wr |=> $stable(cur.cnt) && (cur.phase == PH_ARM));

    // R9: overflow bit is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        cur.ovf && !clr_ovf |=> cur.ovf);

    // R3: held count stays frozen in the hold phase
    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        cur.phase == PH_HOLD && !cnt_wr |=> $stable(cur.cnt));

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cap_in,
    output logic              irq
);
    ctrl_t            ctrl_q;
    edge_t            ed;
    logic             tick;
    logic [CNT_W-1:0] live_cnt, capt;
    logic             done, ovf;
    logic             wr_ctrl, wr_capt, wr_stat;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_capt = reg_wr && (reg_addr == A_CAPT);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en   <= reg_wdata[7];
            ctrl_q.rate <= reg_wdata[6:4];
            ctrl_q.trig <= trig_e'(reg_wdata[1:0]);
        end
    end

    cap_presc #(.PRE_W(PRE_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.en),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    cap_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (cap_in),
        .ed  (ed)
    );

    cap_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .tick      (tick),
        .ed        (ed),
        .clr_done  (wr_stat && reg_wdata[0]),
        .clr_ovf   (wr_stat && reg_wdata[1]),
        .cnt_wr    (wr_capt),
        .cnt_wdata (reg_wdata[CNT_W-1:0]),
        .live_cnt  (live_cnt),
        .capt      (capt),
        .done      (done),
        .ovf       (ovf)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[7]   = ctrl_q.en;
                reg_rdata[6:4] = ctrl_q.rate;
                reg_rdata[1:0] = ctrl_q.trig;
            end
            A_CAPT:  reg_rdata[CNT_W-1:0] = capt;
            A_STAT:  reg_rdata[1:0] = {ovf, done};
            default: reg_rdata[CNT_W-1:0] = live_cnt;
        endcase
    end

    assign irq = done;

endmodule

// File: tb/sim_cap_timer.sv
module sim_cap_timer;
    localparam int CLK_PER = 10;
    localparam int NV = 7;
    localparam int V_MODE [NV] = '{2, 3, 0, 1, 2, 3, 1};
    localparam int V_RATE [NV] = '{7, 7, 6, 5, 0, 4, 7};
    localparam int V_LEN  [NV] = '{40, 64, 80, 96, 1024, 160, 30};
    localparam int V_EXP  [NV] = '{20, 32, 20, 12, 4, 10, 15};

    logic       clk = 0, rst = 1;
    logic [1:0] reg_addr = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       cap_in = 0, irq;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    cap_timer u0 (.clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
                  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                  .cap_in(cap_in), .irq(irq));

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        reg_addr = a; #1;
        v = int'(reg_rdata);
    endtask

    task automatic arm(int mode, int rate);
        cap_in = (mode == 1 || mode == 2) ? 1'b0 : 1'b1;
        cyc(6);
        wr(0, 8'h00);
        wr(0, {1'b1, 3'(rate), 2'b00, 2'(mode)});
        wr(1, 8'h00);
        wr(2, 8'h03);
        cyc(3);
    endtask

    task automatic pulse(int n);
        cap_in = ~cap_in;
        cyc(n);
        cap_in = ~cap_in;
    endtask

    task automatic period(int n);
        cap_in = ~cap_in;
        cyc(n / 2);
        cap_in = ~cap_in;
        cyc(n - n / 2);
        cap_in = ~cap_in;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 capt", v, 0);
        rd(2, v); chk("R1 stat", v, 0);
        rd(3, v); chk("R1 live", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R11 control readback, bits 3:2 read zero; R10 load/read live count
        wr(0, 8'h7F);
        rd(0, v); chk("R11 ctrl", v, 8'h73);
        wr(1, 8'h5A);
        cyc(2);
        rd(3, v); chk("R10 live load", v, 8'h5A);
        wr(0, 8'h00);

        // table: R2 rates, R3 high width, R4 low width, R5 period
        for (int i = 0; i < NV; i++) begin
            arm(V_MODE[i], V_RATE[i]);
            if (V_MODE[i] >= 2) pulse(V_LEN[i]);
            else                period(V_LEN[i]);
            cyc(6);
            rd(1, v);
            chk(V_MODE[i] == 2 ? "R3/R2 capt" : V_MODE[i] == 3 ? "R4/R2 capt" : "R5/R2 capt",
                v, V_LEN[i] >> (8 - V_RATE[i]));
            chk("R2 table", v, V_EXP[i]);
            rd(2, v); chk("R6 stat done", v, 1);
            chk("R6 irq", int'(irq), 1);
        end

        // R6 clear, R3 frozen and not re-armed while flag set, R7 capture kept
        arm(2, 7);
        pulse(40);
        cyc(6);
        rd(1, v); chk("R3 first", v, 20);
        cyc(4);
        pulse(20);
        cyc(6);
        rd(1, v); chk("R7 capt frozen", v, 20);
        rd(3, v); chk("R3 live frozen", v, 20);
        wr(2, 8'h01);
        cyc(2);
        rd(2, v); chk("R6 clear", v, 0);
        chk("R6 irq low", int'(irq), 0);
        wr(1, 8'h00);
        cyc(3);
        pulse(10);
        cyc(6);
        rd(1, v); chk("R3 rearm", v, 5);

        // R5 restart from zero across consecutive periods
        arm(1, 7);
        period(40);
        fork
            begin cyc(24); cap_in = ~cap_in; cyc(24); cap_in = ~cap_in; end
            begin cyc(6); rd(1, v); chk("R5 first", v, 20); wr(2, 8'h01); end
        join
        cyc(6);
        rd(1, v); chk("R5 second", v, 24);
        rd(2, v); chk("R5 stat", v, 1);

        // R9 saturation and sticky overflow, per-bit clear
        arm(2, 7);
        pulse(600);
        cyc(6);
        rd(1, v); chk("R9 sat", v, 255);
        rd(2, v); chk("R9 ovf", v, 3);
        wr(2, 8'h02);
        cyc(1);
        rd(2, v); chk("R9 ovf clear", v, 1);

        // R8 disabled timer ignores edges
        arm(2, 7);
        wr(0, 8'h72);
        cyc(3);
        pulse(40);
        cyc(6);
        rd(2, v); chk("R8 no flag", v, 0);
        rd(3, v); chk("R8 no count", v, 0);
        rd(1, v); chk("R8 capt kept", v, 255);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule